// File: doc/BRIEF.md
# Dual-Path Masked Interrupt Controller

This block collects level-sensitive interrupt requests from on-chip peripherals and drives two exception lines toward a processor core. `irq_o` is the normal request line and `fiq_o` is the fast request line. Each request occupies a fixed bit position in a 32-bit source vector. A software-owned request sits at bit 1 beside the peripheral sources.

Each path has its own register block, and each block has four registers:
- a live view of the raw requests;
- an enable mask that software can only add bits to;
- a write-only register that removes enable bits;
- a masked status, which is the raw view ANDed with that path's enables.

Software can therefore enable or disable one source without a read-modify-write sequence. In the fast block, status bit 0 summarises whether any fast source is active.

The register bus is a plain single-cycle strobe (`bus_we`, `bus_addr`, `bus_wdata`) with a combinational read port (`bus_rdata`). It has no back-pressure: every access completes in the cycle it is presented, and writes take effect at the next rising clock edge. Both exception lines are registered, so each one follows its path's masked status one cycle later.

Top module: `dual_path_intc`

## Requirements
- R1: The implemented source bits are 1 (software), 3–6 (timers), 10–19 (peripherals and external lines), which form the mask 0x000FFC7A. All other bits read 0 in the raw view, the enable registers and the normal status. The only exception is bit 0 of the fast status.
- R2: The raw view reads the current request levels: `periph_req` bits under the mask, with bit 1 taken from the software register. It is at offset 0x4 of each block and is read-only, so writing it changes nothing.
- R3: Writing the enable register (offset 0x8) sets every masked bit written as 1. Bits written as 0 keep their value, so this write never disables a source.
- R4: The enable-clear register (offset 0xC) clears each enable bit written as 1 and leaves all other enable bits unchanged. It reads 0.
- R5: The status register (offset 0x0) reads raw view AND the path's enable mask.
- R6: `irq_o` equals, one clock later, the OR of all bits of the normal-path status.
- R7: The fast block sits at base 0x100 with the same layout and fully independent enables. `fiq_o` equals, one clock later, the OR of its status bits 31:1.
- R8: Bit 0 of the fast status at 0x100 reads 1 exactly when any of its bits 31:1 is 1.
- R9: The software request register at 0x200 is write-only and reads 0. Writing it loads `bus_wdata[1]` as the level of source bit 1.
- R10: A synchronous active-low reset clears both enable masks, the software request and both output lines.
- R11: Reads of any address outside the three register blocks return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| periph_req | input | 32 | Level request per source bit position |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Normal interrupt request line |
| fiq_o | output | 1 | Fast interrupt request line |

## Verification
The bench drives requests on the unused bit positions (0, 2, 7–9 and 20–31). A design that decoded them would raise a line or show a status bit where none may appear. It writes zeros to an enable register that is already set, to catch an enable write that replaces the mask instead of ORing into it. It clears one enable bit with its neighbours set, to catch a clear that disturbs other bits.

It gives the two paths different masks to expose shared or crossed enable storage. It reads the fast status to catch a missing or inverted summary bit. It writes the raw, clear and software registers and reads them back to catch registers that accept writes or return data when they should not. It resets with sources pending, which a design with a lingering line or software bit would fail.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;

  // Implemented source positions: bit 1 (software), 3..6, 10..19.
  localparam logic [DATA_W-1:0] SRC_MASK   = 32'h000F_FC7A;
  localparam int                SWI_BIT    = 1;
  localparam logic [DATA_W-1:0] PERIPH_MASK = SRC_MASK & ~(32'h1 << SWI_BIT);

  // Register offsets inside one path block.
  localparam logic [3:0] OFF_STAT  = 4'h0;
  localparam logic [3:0] OFF_RAW   = 4'h4;
  localparam logic [3:0] OFF_EN    = 4'h8;
  localparam logic [3:0] OFF_ENCLR = 4'hC;

  localparam int NUM_PATHS   = 2;
  localparam int PATH_STRIDE = 'h100;
  localparam int SWI_ADDR    = 'h200;

  typedef enum logic [1:0] {
    REG_STAT  = 2'd0,
    REG_RAW   = 2'd1,
    REG_EN    = 2'd2,
    REG_ENCLR = 2'd3
  } path_reg_e;
endpackage

// File: rtl/intc_src_gather.sv
module intc_src_gather
  import intc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] periph_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] raw_src
);
  localparam logic [ADDR_W-1:0] SWI_A = ADDR_W'(SWI_ADDR);

  logic swi_q;

  // Software request level, write-only register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swi_q <= 1'b0;
    end else if (wr_en && addr == SWI_A) begin
      swi_q <= wdata[SWI_BIT];
    end
  end

  always_comb begin
    raw_src          = periph_req & PERIPH_MASK;
    raw_src[SWI_BIT] = swi_q;
  end
endmodule

// File: rtl/intc_path.sv
module intc_path
  import intc_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          BASE    = 0,
  parameter bit          SUMMARY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] raw_src,
  output logic [DATA_W-1:0] en_q,
  output logic              line_q,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] status;
  logic              any_src;
  path_reg_e         sel;

  assign hit = (addr[ADDR_W-1:4] == BASE_A[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
  assign sel = path_reg_e'(addr[3:2]);

  // Set-only enable writes; separate clear register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en && hit) begin
      if (sel == REG_EN) begin
        en_q <= en_q | (wdata & SRC_MASK);
      end else if (sel == REG_ENCLR) begin
        en_q <= en_q & ~wdata;
      end
    end
  end

  assign masked  = raw_src & en_q;
  assign any_src = |masked[DATA_W-1:1];

  generate
    if (SUMMARY) begin : g_sum
      always_comb begin
        status    = masked;
        status[0] = any_src;
      end
    end else begin : g_plain
      assign status = masked;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
    end else begin
      line_q <= any_src;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      unique case (sel)
        REG_STAT:  rdata = status;
        REG_RAW:   rdata = raw_src;
        REG_EN:    rdata = en_q;
        REG_ENCLR: rdata = '0;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_rd_mux.sv
module intc_rd_mux
  import intc_pkg::*;
#(
  parameter int N = NUM_PATHS
) (
  input  logic [N-1:0]             hit,
  input  logic [N-1:0][DATA_W-1:0] path_rdata,
  output logic [DATA_W-1:0]        rdata
);
  logic [N:0][DATA_W-1:0] acc;

  assign acc[0] = '0;
  generate
    for (genvar i = 0; i < N; i++) begin : g_or
      assign acc[i+1] = acc[i] | (hit[i] ? path_rdata[i] : '0);
    end
  endgenerate
  assign rdata = acc[N];
endmodule

// File: rtl/dual_path_intc.sv
module dual_path_intc
  import intc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       periph_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [DATA_W-1:0]                raw_src;
  logic [NUM_PATHS-1:0][DATA_W-1:0] path_en;
  logic [NUM_PATHS-1:0][DATA_W-1:0] path_rd;
  logic [NUM_PATHS-1:0]             path_hit;
  logic [NUM_PATHS-1:0]             path_line;
  logic [DATA_W-1:0]                irq_en;
  logic [DATA_W-1:0]                fiq_en;

  intc_src_gather #(.ADDR_W(ADDR_W)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_req (periph_req),
    .wr_en      (bus_we),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .raw_src    (raw_src)
  );

  generate
    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      intc_path #(
        .ADDR_W  (ADDR_W),
        .BASE    (p * PATH_STRIDE),
        .SUMMARY (p == 1)
      ) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .raw_src (raw_src),
        .en_q    (path_en[p]),
        .line_q  (path_line[p]),
        .hit     (path_hit[p]),
        .rdata   (path_rd[p])
      );
    end
  endgenerate

  intc_rd_mux #(.N(NUM_PATHS)) u_rd (
    .hit        (path_hit),
    .path_rdata (path_rd),
    .rdata      (bus_rdata)
  );

  assign irq_en = path_en[0];
  assign fiq_en = path_en[1];
  assign irq_o  = path_line[0];
  assign fiq_o  = path_line[1];
endmodule

// File: rtl/dual_path_intc_chk.sv
module dual_path_intc_chk
  import intc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [31:0]       irq_en,
  input logic [31:0]       fiq_en,
  input logic [31:0]       raw_src
);
  p_unused_raw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_src & ~SRC_MASK) == 32'h0);

  p_en_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h008)) |=> ((irq_en & $past(irq_en)) == $past(irq_en)));

  p_en_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h00C)) |=>
      ((irq_en & $past(bus_wdata)) == 32'h0) &&
      ((irq_en & ~$past(bus_wdata)) == ($past(irq_en) & ~$past(bus_wdata))));

  p_wo_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h00C) || bus_addr == ADDR_W'('h10C)) |-> bus_rdata == 32'h0);

  p_irq_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(raw_src & irq_en)));

  p_fiq_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fiq_o == $past(|(raw_src & fiq_en)));

  p_fiq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h10C)) |=> ((fiq_en & $past(bus_wdata)) == 32'h0));

  p_fiq_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h100)) |-> (bus_rdata[0] == (|bus_rdata[31:1])));

  p_swi_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'('h200)) |-> bus_rdata == 32'h0);

  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (irq_en == 32'h0) && (fiq_en == 32'h0) && !irq_o && !fiq_o);
endmodule

bind dual_path_intc dual_path_intc_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dual_path_intc_bench.sv
module dual_path_intc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {req, irq_en, fiq_en, expected irq status, expected fiq status}
  localparam logic [159:0] VEC [NVEC] = '{
    {32'h000F_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h000F_FC78, 32'h0000_0000},
    {32'h0000_0380, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
    {32'h0000_0408, 32'h0000_0008, 32'h0000_0400, 32'h0000_0008, 32'h0000_0401},
    {32'h000C_0000, 32'h0004_0000, 32'h0008_0000, 32'h0004_0000, 32'h0008_0001},
    {32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
    {32'hFFF0_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
    {32'h0001_F000, 32'h0000_0000, 32'h0001_0000, 32'h0000_0000, 32'h0001_0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] periph_req = '0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_path_intc u_dual_path_intc (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R10: reset state
    rd(12'h008, d); chk("R10 irq enable after reset", d, 32'h0);
    rd(12'h108, d); chk("R10 fiq enable after reset", d, 32'h0);
    chk("R10 lines after reset", {30'h0, irq_o, fiq_o}, 32'h0);
    rst_n = 1'b1;

    // Table of patterns: R1 R2 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      wr(12'h00C, 32'hFFFF_FFFF);
      wr(12'h10C, 32'hFFFF_FFFF);
      wr(12'h008, VEC[i][127:96]);
      wr(12'h108, VEC[i][95:64]);
      periph_req = VEC[i][159:128];
      @(negedge clk);
      rd(12'h000, d); chk($sformatf("R5 irq status vec %0d", i), d, VEC[i][63:32]);
      rd(12'h100, d); chk($sformatf("R8 fiq status vec %0d", i), d, VEC[i][31:0]);
      chk($sformatf("R6 irq line vec %0d", i), {31'h0, irq_o}, {31'h0, VEC[i][63:32] != 0});
      chk($sformatf("R7 fiq line vec %0d", i), {31'h0, fiq_o}, {31'h0, VEC[i][31:0] != 0});
    end

    // R1: enable register keeps only implemented bits
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, d); chk("R1 enable mask readback", d, 32'h000F_FC7A);
    // R2: raw view follows requests, writes ignored
    periph_req = 32'h0000_0C00;
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R2 raw view after write", d, 32'h0000_0C00);
    // R3: writing zeros does not disable
    wr(12'h008, 32'h0);
    rd(12'h008, d); chk("R3 enable unchanged by zero write", d, 32'h000F_FC7A);
    // R4: clear one bit, neighbours stay, register reads 0
    wr(12'h00C, 32'h0000_0800);
    rd(12'h008, d); chk("R4 single bit cleared", d, 32'h000F_F47A);
    rd(12'h00C, d); chk("R4 clear register reads 0", d, 32'h0);
    // R7: fast path independent of normal clear
    rd(12'h108, d); chk("R7 fiq enable untouched", d, VEC[NVEC-1][95:64]);
    // R9: software request
    periph_req = 32'h0;
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h008, 32'h0000_0002);
    wr(12'h200, 32'h0000_0002);
    rd(12'h004, d); chk("R9 software bit in raw view", d, 32'h0000_0002);
    rd(12'h200, d); chk("R9 software register reads 0", d, 32'h0);
    @(negedge clk);
    chk("R9 software request raises irq", {31'h0, irq_o}, 32'h1);
    wr(12'h200, 32'hFFFF_FFFD);
    @(negedge clk);
    chk("R9 software request dropped", {31'h0, irq_o}, 32'h0);
    // R11: unmapped addresses
    rd(12'h300, d); chk("R11 unmapped read", d, 32'h0);
    rd(12'h010, d); chk("R11 gap read", d, 32'h0);
    // R10: reset with sources pending
    wr(12'h200, 32'h0000_0002);
    wr(12'h108, 32'h0000_0002);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rd(12'h004, d); chk("R10 software bit cleared", d, 32'h0);
    rd(12'h108, d); chk("R10 fiq enable cleared", d, 32'h0);
    chk("R10 lines cleared", {30'h0, irq_o, fiq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule